// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a purely combinational function unit for an n-bit datapath. It takes two operands, a four-bit function select, a carry input and two serial fill bits, and returns one result word and a carry output in the same cycle. Any registering of the result belongs to the surrounding logic.

The two upper select bits choose which section drives the result. The choices are an adder, a bitwise logic section, a one-place right shift or a one-place left shift. In adder mode the two lower select bits choose the adder's second operand: zeros, B, the inverse of B, or ones. The carry input is then added to the sum. This single encoding covers transfer, increment, add, add-with-carry, subtract-with-borrow, subtract and decrement. In logic mode the lower select bits choose AND, OR, XOR or inversion of A. The carry output is valid only in adder mode.

Top module: `alsu_top`

## Requirements
- R1: With funcSel[3:2]=00, result equals (opA + Y + carryIn) mod 2^W, where funcSel[1:0] selects Y: 00 all zeros, 01 opB, 10 bitwise inverse of opB, 11 all ones.
- R2: In adder mode, carryOut is bit W of the full sum opA + Y + carryIn.
- R3: In adder mode, funcSel[1:0]=10 with carryIn=1 yields opA-opB with carryOut=1 exactly when opA>=opB. funcSel[1:0]=11 with carryIn=0 yields opA-1. funcSel[1:0]=11 with carryIn=1 yields opA with carryOut=1.
- R4: With funcSel[3:2]=01, result is opA AND opB for funcSel[1:0]=00, OR for 01, XOR for 10, and the bitwise inverse of opA for 11.
- R5: In logic mode, carryIn has no effect on result.
- R6: With funcSel[3:2]=10, result[i]=opA[i+1] for i<W-1, and result[W-1]=serInRight.
- R7: With funcSel[3:2]=11, result[i]=opA[i-1] for i>0, and result[0]=serInLeft.
- R8: carryOut is 0 whenever funcSel[3:2] is not 00.
- R9: In both shift modes, funcSel[1:0], opB and carryIn have no effect on result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | W | First operand, also the shift source |
| opB | input | W | Second operand |
| funcSel | input | 4 | Function select: [3:2] section, [1:0] sub-operation |
| carryIn | input | 1 | Carry into the adder |
| serInRight | input | 1 | Bit that enters the MSB on a right shift |
| serInLeft | input | 1 | Bit that enters the LSB on a left shift |
| result | output | W | Selected result |
| carryOut | output | 1 | Adder carry in adder mode, else 0 |

## Verification
The immediate assertions assume that every input is a known 0 or 1. An X on funcSel would make the section strobes non-one-hot, and the checks on those strobes would then be meaningless. They also assume each check is evaluated after the combinational network has settled for the current inputs. The bench drives only defined values and changes all inputs together. It samples one time unit later, and it walks every select code with corner operands (zero, all ones, MSB only, alternating bits) so that carry and fill-bit cases are reached.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  // Which section drives the result; exactly one strobe is high.
  typedef struct packed {
    logic       pickArith;
    logic       pickLogic;
    logic       pickShr;
    logic       pickShl;
    logic [1:0] operandSel;  // adder second-operand choice
    logic [1:0] logicOp;     // logic section operation
  } alsu_ctrl_t;

  localparam logic [1:0] SEC_ARITH = 2'b00;
  localparam logic [1:0] SEC_LOGIC = 2'b01;
  localparam logic [1:0] SEC_SHR   = 2'b10;
  localparam logic [1:0] SEC_SHL   = 2'b11;

  localparam logic [1:0] Y_ZERO = 2'b00;
  localparam logic [1:0] Y_B    = 2'b01;
  localparam logic [1:0] Y_NOTB = 2'b10;
  localparam logic [1:0] Y_ONES = 2'b11;

  localparam logic [1:0] L_AND  = 2'b00;
  localparam logic [1:0] L_OR   = 2'b01;
  localparam logic [1:0] L_XOR  = 2'b10;
  localparam logic [1:0] L_NOTA = 2'b11;

endpackage

// File: rtl/alsu_ctrl.sv
module alsu_ctrl
  import alsu_pkg::*;
(
  input  logic [3:0] funcSel,
  output alsu_ctrl_t ctrl
);

  logic [1:0] section;
  assign section = funcSel[3:2];

  always_comb begin
    ctrl = '0;
    ctrl.operandSel = funcSel[1:0];
    ctrl.logicOp    = funcSel[1:0];
    unique case (section)
      SEC_ARITH: ctrl.pickArith = 1'b1;
      SEC_LOGIC: ctrl.pickLogic = 1'b1;
      SEC_SHR:   ctrl.pickShr   = 1'b1;
      default:   ctrl.pickShl   = 1'b1;
    endcase
  end

endmodule

// File: rtl/alsu_arith.sv
module alsu_arith
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   operandSel,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  localparam int SW = W + 1;

  logic [W-1:0]  yOp;
  logic [SW-1:0] wide;

  always_comb begin
    unique case (operandSel)
      Y_ZERO:  yOp = '0;
      Y_B:     yOp = b;
      Y_NOTB:  yOp = ~b;
      default: yOp = '1;
    endcase
  end

  assign wide = {1'b0, a} + {1'b0, yOp} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];

  always_comb begin
    // R1
    if (operandSel == Y_ZERO && !cin)
      transfer_chk: assert (sum == a && !cout);
    // R3
    if (operandSel == Y_ONES && cin)
      wrap_chk: assert (sum == a && cout);
  end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   logicOp,
  output logic [W-1:0] f
);

  for (genvar i = 0; i < W; i++) begin : g_slice
    always_comb begin
      unique case (logicOp)
        L_AND:   f[i] = a[i] & b[i];
        L_OR:    f[i] = a[i] | b[i];
        L_XOR:   f[i] = a[i] ^ b[i];
        default: f[i] = ~a[i];
      endcase
    end
  end

  always_comb begin
    // R4
    if (logicOp == L_XOR)
      xor_chk: assert ((f ^ b) == a);
    // R4
    if (logicOp == L_NOTA)
      invert_chk: assert ((f & a) == '0 && (f | a) == '1);
  end

endmodule

// File: rtl/alsu_datapath.sv
module alsu_datapath
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  alsu_ctrl_t   ctrl,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         carryIn,
  input  logic         serInRight,
  input  logic         serInLeft,
  output logic [W-1:0] result,
  output logic         carryOut
);

  logic [W-1:0] arithOut;
  logic         arithCarry;
  logic [W-1:0] logicOut;
  logic [W-1:0] shrOut;
  logic [W-1:0] shlOut;

  alsu_arith #(.W(W)) u_arith (
    .a          (opA),
    .b          (opB),
    .operandSel (ctrl.operandSel),
    .cin        (carryIn),
    .sum        (arithOut),
    .cout       (arithCarry)
  );

  alsu_logic #(.W(W)) u_logic (
    .a       (opA),
    .b       (opB),
    .logicOp (ctrl.logicOp),
    .f       (logicOut)
  );

  assign shrOut = {serInRight, opA[W-1:1]};
  assign shlOut = {opA[W-2:0], serInLeft};

  always_comb begin
    result = ({W{ctrl.pickArith}} & arithOut)
           | ({W{ctrl.pickLogic}} & logicOut)
           | ({W{ctrl.pickShr}}   & shrOut)
           | ({W{ctrl.pickShl}}   & shlOut);
    carryOut = ctrl.pickArith & arithCarry;
  end

endmodule

// File: rtl/alsu_top.sv
module alsu_top
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [3:0]   funcSel,
  input  logic         carryIn,
  input  logic         serInRight,
  input  logic         serInLeft,
  output logic [W-1:0] result,
  output logic         carryOut
);

  alsu_ctrl_t ctrl;

  alsu_ctrl u_ctrl (
    .funcSel (funcSel),
    .ctrl    (ctrl)
  );

  alsu_datapath #(.W(W)) u_dp (
    .ctrl       (ctrl),
    .opA        (opA),
    .opB        (opB),
    .carryIn    (carryIn),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .result     (result),
    .carryOut   (carryOut)
  );

  always_comb begin
    // R8
    if (funcSel[3:2] != SEC_ARITH)
      no_carry_chk: assert (carryOut == 1'b0);
    // R6
    if (funcSel[3:2] == SEC_SHR)
      shr_fill_chk: assert (result[W-1] == serInRight && result[0] == opA[1]);
    // R7
    if (funcSel[3:2] == SEC_SHL)
      shl_fill_chk: assert (result[0] == serInLeft && result[W-1] == opA[W-2]);
  end

endmodule

// File: tb/alsu_top_test.sv
module alsu_top_test;

  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opA, opB;
  logic [3:0]   funcSel;
  logic         carryIn, serInRight, serInLeft;
  logic [W-1:0] result;
  logic         carryOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  alsu_top #(.W(W)) uut (
    .opA(opA), .opB(opB), .funcSel(funcSel), .carryIn(carryIn),
    .serInRight(serInRight), .serInLeft(serInLeft),
    .result(result), .carryOut(carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] pats [6] = '{8'h00, 8'hFF, 8'h80, 8'h55, 8'hA3, 8'h01};

  // Expected value built from the requirement text.
  function automatic void model(input logic [W-1:0] a, b, input logic [3:0] s,
                                input logic c, sr, sl,
                                output logic [W-1:0] f, output logic co);
    logic [W-1:0] y;
    int full;
    co = 1'b0;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: y = '0;
          2'b01: y = b;
          2'b10: y = ~b;
          default: y = '1;
        endcase
        full = int'(a) + int'(y) + int'(c);
        f = full[W-1:0];
        co = full[W];
      end
      2'b01: begin
        case (s[1:0])
          2'b00: f = a & b;
          2'b01: f = a | b;
          2'b10: f = a ^ b;
          default: f = ~a;
        endcase
      end
      2'b10: f = {sr, a[W-1:1]};
      default: f = {a[W-2:0], sl};
    endcase
  endfunction

  task automatic apply(input logic [W-1:0] a, b, input logic [3:0] s,
                       input logic c, sr, sl);
    opA = a; opB = b; funcSel = s; carryIn = c; serInRight = sr; serInLeft = sl;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] expF, input logic expC);
    total++;
    if (result !== expF || carryOut !== expC) begin
      bad++;
      $display("FAIL %s sel=%b a=%h b=%h cin=%b: result=%h carry=%b expected result=%h carry=%b",
               req, funcSel, opA, opB, carryIn, result, carryOut, expF, expC);
    end
  endtask

  task automatic checkModel(input string req);
    logic [W-1:0] f;
    logic co;
    model(opA, opB, funcSel, carryIn, serInRight, serInLeft, f, co);
    check(req, f, co);
  endtask

  task automatic testIdle();
    apply('0, '0, 4'b0000, 1'b0, 1'b0, 1'b0);
    check("R1 idle", '0, 1'b0);
  endtask

  // R1 R2: all adder sub-operations over corner operands
  task automatic testArith();
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++)
        for (int i = 0; i < 6; i++)
          for (int j = 0; j < 6; j++) begin
            apply(pats[i], pats[j], {2'b00, 2'(s)}, 1'(c), 1'b0, 1'b0);
            checkModel("R1/R2 adder");
          end
  endtask

  // R3: named subtract, decrement and wrap cases
  task automatic testSubtract();
    apply(8'd20, 8'd7, 4'b0010, 1'b1, 1'b0, 1'b0);
    check("R3 sub a>b", 8'd13, 1'b1);
    apply(8'd7, 8'd20, 4'b0010, 1'b1, 1'b0, 1'b0);
    check("R3 sub a<b", 8'd243, 1'b0);
    apply(8'd9, 8'd9, 4'b0010, 1'b1, 1'b0, 1'b0);
    check("R3 sub equal", 8'd0, 1'b1);
    apply(8'd0, 8'd0, 4'b0011, 1'b0, 1'b0, 1'b0);
    check("R3 decrement zero", 8'hFF, 1'b0);
    apply(8'h40, 8'h00, 4'b0011, 1'b0, 1'b0, 1'b0);
    check("R3 decrement", 8'h3F, 1'b1);
    apply(8'hC6, 8'h11, 4'b0011, 1'b1, 1'b0, 1'b0);
    check("R3 ones plus carry", 8'hC6, 1'b1);
    apply(8'hFF, 8'h00, 4'b0000, 1'b1, 1'b0, 1'b0);
    check("R2 increment wrap", 8'h00, 1'b1);
  endtask

  // R4 R5 R8: logic ops, both carry-in values
  task automatic testLogic();
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          logic [W-1:0] f0;
          apply(pats[i], pats[j], {2'b01, 2'(s)}, 1'b0, 1'b0, 1'b0);
          checkModel("R4 logic");
          f0 = result;
          apply(pats[i], pats[j], {2'b01, 2'(s)}, 1'b1, 1'b1, 1'b1);
          check("R5/R8 logic cin ignored", f0, 1'b0);
        end
  endtask

  // R6 R7 R8: both shifts with both fill bits
  task automatic testShift();
    for (int d = 0; d < 2; d++)
      for (int fill = 0; fill < 2; fill++)
        for (int i = 0; i < 6; i++) begin
          apply(pats[i], 8'h00, {1'b1, 1'(d), 2'b00}, 1'b0, 1'(fill), 1'(~fill));
          checkModel(d == 0 ? "R6 shift right" : "R7 shift left");
        end
    apply(8'h81, 8'h00, 4'b1000, 1'b1, 1'b1, 1'b0);
    check("R6 msb fill", 8'hC0, 1'b0);
    apply(8'h81, 8'h00, 4'b1100, 1'b1, 1'b0, 1'b1);
    check("R7 lsb fill", 8'h03, 1'b0);
  endtask

  // R9: low select bits, opB and carryIn do not change a shift
  task automatic testShiftIgnore();
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 4; s++) begin
        logic [W-1:0] expF;
        expF = (d == 0) ? 8'h5B : 8'h6D;
        apply(8'hB6, pats[s], {1'b1, 1'(d), 2'(s)}, 1'(s), 1'b0, 1'b1);
        check("R9 shift ignores sel/b/cin", expF, 1'b0);
      end
  endtask

  initial begin
    opA = '0; opB = '0; funcSel = '0; carryIn = 0; serInRight = 0; serInLeft = 0;
    #(CLK_PERIOD * 2);
    rst = 1'b0;
    @(negedge clk);
    testIdle();
    testArith();
    testSubtract();
    testLogic();
    testShift();
    testShiftIgnore();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule